// File: doc/BRIEF.md
# Receive Frame Parser with CRC-32 Check

This block sits after an external 8b10b decoder on one lane and turns the decoded byte stream into user payload. Each incoming byte carries a flag that says whether it is a control character. The parser hunts for frame starts, tells link-keeping idle frames apart from data frames, and drops the idle frames entirely. Inside a data frame it forwards every plain data byte to the user side, strips filler control characters, and runs a CRC-32 over the forwarded bytes. It compares that result with the checksum that trails the frame.

Both frame kinds end in a flow-control token that reports the far end's free receive space. The parser latches that byte as the remote token. Two status inputs, lane valid and word lock, gate the whole parser. A registered link-up output reports that both are present.

There is no back-pressure anywhere. The line side cannot be stalled, so the input has a valid qualifier only. The user side gets a valid strobe with no ready and must take every byte in the cycle it is offered. Storage for rate matching belongs downstream.

Top module: `lfp_frame_parser`

## Requirements
- R1: `link_up` is 0 in reset and afterwards equals the AND of `lane_ok` and `word_lock` sampled one clock earlier.
- R2: A byte is taken only in a cycle with `in_vld`, `lane_ok` and `word_lock` all high. If either status input drops, the frame in progress is abandoned without an error pulse and without a token update.
- R3: A data frame starts with a control-flagged 0x3C. Each following non-control byte appears on `out_byte` with `out_vld` high exactly one clock after it was taken, in arrival order.
- R4: Control-flagged 0x9C filler bytes inside a payload are never forwarded and do not enter the CRC.
- R5: A control-flagged 0xFC ends the payload. It is followed by one reserved byte, four checksum bytes with the least significant byte first, and one token byte. The control flag of these six bytes is not examined.
- R6: The checksum is the bit-reflected CRC-32 with generator 0x04C11DB7, seeded with all ones and inverted at the end, taken over the payload data bytes. A mismatch gives a one-clock `crc_err` pulse one clock after the token byte. A match gives no pulse.
- R7: The token byte of a data frame appears on `far_token` one clock after it was taken, whether or not the checksum matched.
- R8: An idle frame starts with a control-flagged 0x1C, 0x7C or 0xBC and is IDLE_LEN bytes long. It forwards nothing, and its last byte appears on `far_token` one clock later.
- R9: A control-flagged 0x3C inside a payload discards the partial frame from the parser's view. It pulses `crc_err` for one clock one clock later and starts a fresh frame.
- R10: A payload data byte beyond MAX_PAYLOAD is not forwarded. It pulses `crc_err` for one clock one clock later, and the parser returns to hunting.
- R11: While hunting, every byte other than the four start characters is ignored: no output and no token change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_ok | input | 1 | Lane receiver working |
| word_lock | input | 1 | Decoder word boundary found |
| in_vld | input | 1 | Input byte valid |
| in_k | input | 1 | Input byte is a control character |
| in_byte | input | 8 | Decoded input byte |
| link_up | output | 1 | Registered lane-ready status |
| out_vld | output | 1 | Payload byte valid, no ready |
| out_byte | output | 8 | Payload byte |
| crc_err | output | 1 | One-clock frame error pulse |
| far_token | output | 8 | Last remote token received |

## Verification
The bench builds the block with its default parameters, MAX_PAYLOAD of 128 and IDLE_LEN of 8. Because the payload limit stays at full size, a sweep over every payload length from zero through one beyond the limit is cheap. That sweep reaches the empty-payload checksum, the exact-limit frame and the overflow byte, and it crosses lengths with filler bytes, input bubbles and corrupted checksums. Every idle start character is paired with a range of token values. The status-drop, early-start and hunt-garbage cases are then driven one by one.

// File: rtl/lfp_pkg.sv
package lfp_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_IDLE,
    ST_DATA,
    ST_TAIL
  } lfp_state_e;

  localparam logic [7:0] K_SOF   = 8'h3C;
  localparam logic [7:0] K_EOF   = 8'hFC;
  localparam logic [7:0] K_PAD   = 8'h9C;
  localparam logic [7:0] K_IDL_A = 8'h7C;
  localparam logic [7:0] K_IDL_K = 8'hBC;
  localparam logic [7:0] K_IDL_R = 8'h1C;

  localparam logic [31:0] CRC_GEN = 32'h04C11DB7;

  function automatic logic [31:0] flip32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

endpackage

// File: rtl/lfp_crc32_step.sv
module lfp_crc32_step
  import lfp_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  data,
  output logic [31:0] crc_out
);

  localparam logic [31:0] GEN_REFL = flip32(CRC_GEN);

  logic [31:0] work;

  always_comb begin
    work = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (work[0] ^ data[b]) work = (work >> 1) ^ GEN_REFL;
      else                   work = work >> 1;
    end
    crc_out = work;
  end

endmodule

// File: rtl/lfp_link_status.sv
module lfp_link_status (
  input  logic clk,
  input  logic rst_n,
  input  logic lane_ok,
  input  logic word_lock,
  output logic link_up
);

  always_ff @(posedge clk) begin
    if (!rst_n) link_up <= 1'b0;
    else        link_up <= lane_ok & word_lock;
  end

  // R1
  link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> $past(lane_ok && word_lock));

endmodule

// File: rtl/lfp_frame_parser.sv
module lfp_frame_parser
  import lfp_pkg::*;
#(
  parameter int MAX_PAYLOAD = 128,
  parameter int IDLE_LEN    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lane_ok,
  input  logic       word_lock,
  input  logic       in_vld,
  input  logic       in_k,
  input  logic [7:0] in_byte,
  output logic       link_up,
  output logic       out_vld,
  output logic [7:0] out_byte,
  output logic       crc_err,
  output logic [7:0] far_token
);

  localparam int TAIL_LEN = 6;
  localparam int CNT_W    = $clog2(MAX_PAYLOAD + 1);
  localparam int POS_MAX  = (IDLE_LEN > TAIL_LEN) ? IDLE_LEN : TAIL_LEN;
  localparam int POS_W    = $clog2(POS_MAX);

  localparam logic [CNT_W-1:0] CNT_CAP   = CNT_W'(MAX_PAYLOAD);
  localparam logic [POS_W-1:0] IDLE_LAST = POS_W'(IDLE_LEN - 1);
  localparam logic [POS_W-1:0] TAIL_LAST = POS_W'(TAIL_LEN - 1);

  lfp_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pos;
  logic [31:0]      crc_q;
  logic [31:0]      crc_nxt;
  logic [31:0]      rcv_crc;

  logic lane_ready, is_sof, is_eof, is_idle_start;

  assign lane_ready    = lane_ok & word_lock;
  assign is_sof        = in_k && (in_byte == K_SOF);
  assign is_eof        = in_k && (in_byte == K_EOF);
  assign is_idle_start = in_k && ((in_byte == K_IDL_A) || (in_byte == K_IDL_K) ||
                                  (in_byte == K_IDL_R));

  lfp_link_status i_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_ok   (lane_ok),
    .word_lock (word_lock),
    .link_up   (link_up)
  );

  lfp_crc32_step i_crc (
    .crc_in  (crc_q),
    .data    (in_byte),
    .crc_out (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HUNT;
      cnt       <= '0;
      pos       <= '0;
      crc_q     <= '1;
      rcv_crc   <= '0;
      out_vld   <= 1'b0;
      out_byte  <= '0;
      crc_err   <= 1'b0;
      far_token <= '0;
    end else begin
      out_vld <= 1'b0;
      crc_err <= 1'b0;
      if (!lane_ready) begin
        st <= ST_HUNT;
      end else if (in_vld) begin
        unique case (st)
          ST_HUNT: begin
            if (is_sof) begin
              st    <= ST_DATA;
              cnt   <= '0;
              crc_q <= '1;
            end else if (is_idle_start) begin
              st  <= ST_IDLE;
              pos <= POS_W'(1);
            end
          end
          ST_IDLE: begin
            if (pos == IDLE_LAST) begin
              far_token <= in_byte;
              st        <= ST_HUNT;
            end else begin
              pos <= pos + 1'b1;
            end
          end
          ST_DATA: begin
            if (is_sof) begin
              crc_err <= 1'b1;
              cnt     <= '0;
              crc_q   <= '1;
            end else if (is_eof) begin
              st  <= ST_TAIL;
              pos <= '0;
            end else if (!in_k) begin
              if (cnt == CNT_CAP) begin
                crc_err <= 1'b1;
                st      <= ST_HUNT;
              end else begin
                out_vld  <= 1'b1;
                out_byte <= in_byte;
                crc_q    <= crc_nxt;
                cnt      <= cnt + 1'b1;
              end
            end
          end
          ST_TAIL: begin
            if (pos == TAIL_LAST) begin
              far_token <= in_byte;
              crc_err   <= (rcv_crc != ~crc_q);
              st        <= ST_HUNT;
            end else begin
              if (pos != '0) rcv_crc <= {in_byte, rcv_crc[31:8]};
              pos <= pos + 1'b1;
            end
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  // R3 R4
  out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld && !in_k));

  // R2
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(lane_ok && word_lock));

  // R10
  payload_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_CAP);

  // R7 R8
  token_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(far_token) |-> $past(in_vld && lane_ready && (st == ST_IDLE || st == ST_TAIL)));

  // R6 R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> $past(in_vld && lane_ready && (st == ST_DATA || st == ST_TAIL)));

endmodule

// File: tb/test_lfp_frame_parser.sv
module test_lfp_frame_parser;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP       = 128;

  logic       clk = 1'b0;
  logic       rst_n, lane_ok, word_lock, in_vld, in_k;
  logic [7:0] in_byte;
  logic       link_up, out_vld, crc_err;
  logic [7:0] out_byte, far_token;

  int checks = 0;
  int fails  = 0;
  int err_cnt = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] cur_tok = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfp_frame_parser i_lfp_frame_parser (
    .clk(clk), .rst_n(rst_n), .lane_ok(lane_ok), .word_lock(word_lock),
    .in_vld(in_vld), .in_k(in_k), .in_byte(in_byte),
    .link_up(link_up), .out_vld(out_vld), .out_byte(out_byte),
    .crc_err(crc_err), .far_token(far_token)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_vld) got_q.push_back(out_byte);
      if (crc_err) err_cnt++;
    end
  end

  function automatic logic [31:0] bstep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int i = 0; i < 8; i++)
      r = ((r[0] ^ d[i]) != 1'b0) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic k, input logic [7:0] b);
    @(negedge clk);
    in_vld = 1'b1; in_k = k; in_byte = b;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0; in_k = 1'b0; in_byte = 8'h00;
    end
  endtask

  task automatic settle(input string tag, input int exp_err, input logic [7:0] exp_tok);
    int bad = 0;
    gap(3);
    check({tag, " R3 payload count"}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) bad++;
    check({tag, " R3 R4 payload bytes"}, bad, 0);
    check({tag, " R6 error pulses"}, err_cnt, exp_err);
    check({tag, " R7 R8 token"}, far_token, exp_tok);
    got_q.delete(); exp_q.delete(); err_cnt = 0;
  endtask

  task automatic send_frame(input int len, input bit pads, input bit bubbles,
                            input bit corrupt, input logic [7:0] tok);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] f;
    logic [7:0]  d;
    put(1'b1, 8'h3C);
    for (int i = 0; i < len; i++) begin
      if (pads && (i % 5 == 2)) put(1'b1, 8'h9C);
      d = 8'(len * 7 + i * 13 + 5);
      put(1'b0, d);
      if (i < MAXP) exp_q.push_back(d);
      c = bstep(c, d);
      if (bubbles && (i % 3 == 0)) gap(1);
    end
    if (pads) put(1'b1, 8'h9C);
    put(1'b1, 8'hFC);
    put(1'b0, 8'hA5);
    f = ~c;
    if (corrupt) f = f ^ 32'h0000_0100;
    for (int j = 0; j < 4; j++) put(1'b0, f[8*j +: 8]);
    put(1'b0, tok);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lane_ok = 1'b1; word_lock = 1'b1;
    in_vld = 1'b0; in_k = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("reset R1 link_up", link_up, 0);
    check("reset R3 out_vld", out_vld, 0);
    check("reset R6 crc_err", crc_err, 0);
    check("reset R7 token", far_token, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 link_up after reset", link_up, 1);

    // length sweep past the payload limit (R10 at len 129)
    for (int len = 0; len <= MAXP + 1; len++) begin
      logic [7:0] tok = 8'(len + 1);
      bit corrupt = (len % 7 == 3);
      send_frame(len, len % 3 == 1, len % 4 == 2, corrupt, tok);
      if (len > MAXP) begin
        settle("R10 overflow", 1, cur_tok);
      end else begin
        cur_tok = tok;
        settle("R5 R6 sweep", corrupt ? 1 : 0, cur_tok);
      end
    end

    // idle frames, every start character
    for (int s = 0; s < 3; s++) begin
      for (int t = 0; t < 5; t++) begin
        logic [7:0] st_c = (s == 0) ? 8'h1C : (s == 1) ? 8'h7C : 8'hBC;
        logic [7:0] tv = (t == 0) ? 8'h00 : (t == 1) ? 8'h01 : (t == 2) ? 8'h02 :
                         (t == 3) ? 8'h7F : 8'hFF;
        put(1'b1, st_c);
        for (int f = 0; f < 6; f++) put(1'b1, (f % 2 == 0) ? 8'hBC : 8'h1C);
        put(1'b0, tv);
        cur_tok = tv;
        settle("R8 idle", 0, cur_tok);
      end
    end

    // second start character inside a payload
    begin
      logic [31:0] c = 32'hFFFFFFFF;
      logic [31:0] f;
      put(1'b1, 8'h3C);
      for (int i = 0; i < 4; i++) begin put(1'b0, 8'(8'h30 + i)); exp_q.push_back(8'(8'h30 + i)); end
      put(1'b1, 8'h3C);
      for (int i = 0; i < 2; i++) begin
        put(1'b0, 8'(8'hC0 + i)); exp_q.push_back(8'(8'hC0 + i)); c = bstep(c, 8'(8'hC0 + i));
      end
      put(1'b1, 8'h9C);
      put(1'b1, 8'hFC);
      put(1'b0, 8'h00);
      f = ~c;
      for (int j = 0; j < 4; j++) put(1'b0, f[8*j +: 8]);
      put(1'b0, 8'h44);
      cur_tok = 8'h44;
      settle("R9 early start", 1, cur_tok);
    end

    // garbage while hunting
    put(1'b1, 8'hFC); put(1'b1, 8'h9C); put(1'b0, 8'h3C); put(1'b0, 8'h7C);
    put(1'b1, 8'h00); put(1'b0, 8'h55);
    settle("R11 hunt garbage", 0, cur_tok);

    // status drop mid-frame
    put(1'b1, 8'h3C);
    for (int i = 0; i < 3; i++) begin put(1'b0, 8'(8'h90 + i)); exp_q.push_back(8'(8'h90 + i)); end
    @(negedge clk);
    word_lock = 1'b0; in_vld = 1'b1; in_k = 1'b0; in_byte = 8'h11;
    @(negedge clk);
    check("R1 link_up drops", link_up, 0);
    word_lock = 1'b1; in_vld = 1'b0;
    put(1'b0, 8'h12); put(1'b0, 8'h13); put(1'b1, 8'hFC); put(1'b0, 8'h00);
    for (int j = 0; j < 4; j++) put(1'b0, 8'(8'hE0 + j));
    put(1'b0, 8'h66);
    settle("R2 status drop", 0, cur_tok);
    check("R1 link_up restored", link_up, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule